// File: doc/BRIEF.md
# Programmable IP Security Wrapper

This block sits at the boundary of one IP core and gives a central security policy engine a view into that core and control over it. During boot the engine writes an event mask. The mask chooses which of the core's observable status signals count as events of interest. It also chooses whether attempts to reach a protected register window in a neighbouring core are reported. At run time the first selected event is packed into a 32-bit frame. The frame is held behind a flag on a dedicated security port, separate from any debug trace path, and the engine drains it in two 16-bit beats.

The wrapper also carries one controllable output: an engine-set access disable. While the disable is on, register requests from the core that fall inside the protected window are held back. The core instead receives a one-cycle error pulse. The disable stays at the value the engine last wrote. A second event that arrives while a frame is still unread raises a sticky overflow bit and leaves the held frame unchanged.

Top module: `ipg_wrapper`

## Requirements
- R1: After reset the frame flag, overflow bit, error response and frame word are all 0, the disable is off and the event mask is clear.
- R2: An engine write to config address 0 loads the mask from cfg_wdata[NSIG:0]. A rising edge on mon_sig[i] whose mask bit i is set is captured at that clock edge, and the flag is seen high after it. The frame layout is: bits [31:28] wrapper ID, [27:24] event code i+1, [23:17] zero, [16] read/write bit (1 = write), [15:0] request address (0 for signal events).
- R3: Rising edges on signals whose mask bit is clear produce no frame. Window accesses produce no frame while mask bit NSIG is clear.
- R4: While mask bit NSIG is set, a valid request whose address lies in the window [WIN_BASE, WIN_BASE+WIN_SIZE) produces a frame with event code 15, the request address and the write bit. This happens whether or not the request is blocked.
- R5: When several events occur in one cycle, a window access wins over signal events. Among signal events, the lowest index wins.
- R6: While the flag is high, each cycle with eng_rd high is one read beat. The first beat shows frame bits [15:0] on frm_word and the second shows bits [31:16]. The flag falls after the second beat. Without eng_rd, the flag and frm_word hold.
- R7: An event in any cycle where a frame is pending sets frm_ovf and does not alter the pending frame. frm_ovf stays set until the engine writes config address 2.
- R8: With the disable on (config address 1, bit 0 = 1), a request into the window gives fwd_valid low in the same cycle and req_err high for exactly the next cycle.
- R9: With the disable off, or for addresses outside the window (including WIN_BASE+WIN_SIZE), a request is forwarded in the same cycle with unchanged address and write bit, and req_err stays low.
- R10: The disable remains in force across any number of cycles until the engine writes 0 to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Engine configuration write strobe |
| cfg_addr | input | 2 | Config select: 0 mask, 1 disable, 2 overflow clear |
| cfg_wdata | input | 16 | Configuration write data |
| mon_sig | input | NSIG | Observable status signals of the IP |
| req_valid | input | 1 | IP outgoing register request valid |
| req_we | input | 1 | Request is a write |
| req_addr | input | AW | Request register address |
| fwd_valid | output | 1 | Request forwarded to the fabric |
| fwd_we | output | 1 | Forwarded write bit |
| fwd_addr | output | AW | Forwarded address |
| req_err | output | 1 | One-cycle error response for a blocked request |
| eng_rd | input | 1 | Engine read beat strobe |
| frm_flag | output | 1 | Frame pending |
| frm_word | output | 16 | Current half of the pending frame |
| frm_ovf | output | 1 | Sticky overflow |

## Verification
The hardest situation to reach is a collision. This means an event arriving while a frame is pending, and especially in the very cycle of the final read beat, where the frame must stay intact and only the overflow bit may move. The stimulus first leaves a frame unread. It then raises further masked signals, both between beats and together with the closing beat. Finally it drains the buffer and checks that the first frame, not a later one, comes out. Same-cycle priority is reached by raising a window request and two signal edges on one clock.

// File: rtl/ipg_pkg.sv
package ipg_pkg;

    localparam logic [3:0] CODE_WIN = 4'hF;

    localparam logic [1:0] CFG_MASK    = 2'd0;
    localparam logic [1:0] CFG_DISABLE = 2'd1;
    localparam logic [1:0] CFG_OVFCLR  = 2'd2;

    typedef struct packed {
        logic [3:0]  id;
        logic [3:0]  code;
        logic [6:0]  rsvd;
        logic        rw;
        logic [15:0] addr;
    } frame_t;

    function automatic logic [3:0] sig_code(input int idx);
        return 4'(idx + 1);
    endfunction

endpackage

// File: rtl/ipg_access_gate.sv
module ipg_access_gate #(
    parameter int AW       = 8,
    parameter int WIN_BASE = 0,
    parameter int WIN_SIZE = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          disable_on,
    input  logic          req_valid,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    output logic          fwd_valid,
    output logic          fwd_we,
    output logic [AW-1:0] fwd_addr,
    output logic          req_err,
    output logic          win_hit
);
    localparam logic [AW:0] BASE_X = (AW+1)'(WIN_BASE);
    localparam logic [AW:0] SIZE_X = (AW+1)'(WIN_SIZE);

    logic [AW:0] offset;
    logic        in_win;
    logic        blocked;
    logic        err_q;

    // unsigned wrap turns addresses below the base into huge offsets
    assign offset    = {1'b0, req_addr} - BASE_X;
    assign in_win    = offset < SIZE_X;
    assign win_hit   = req_valid & in_win;
    assign blocked   = win_hit & disable_on;
    assign fwd_valid = req_valid & ~blocked;
    assign fwd_we    = req_we;
    assign fwd_addr  = req_addr;

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= blocked;
    end

    assign req_err = err_q;
endmodule

// File: rtl/ipg_event_detect.sv
module ipg_event_detect
    import ipg_pkg::*;
#(
    parameter int         NSIG    = 8,
    parameter int         AW      = 8,
    parameter logic [3:0] WRAP_ID = 4'h3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NSIG:0] mask,
    input  logic [NSIG-1:0] mon_sig,
    input  logic          win_hit,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    output logic          ev_valid,
    output frame_t        ev_frame
);
    logic [NSIG-1:0] mon_q;
    logic [NSIG-1:0] rise;

    for (genvar g = 0; g < NSIG; g++) begin : g_edge
        always_ff @(posedge clk) begin
            if (rst) mon_q[g] <= 1'b0;
            else     mon_q[g] <= mon_sig[g];
        end
        assign rise[g] = mon_sig[g] & ~mon_q[g] & mask[g];
    end

    logic win_ev;
    assign win_ev = win_hit & mask[NSIG];

    always_comb begin
        ev_frame      = '0;
        ev_frame.id   = WRAP_ID;
        ev_valid      = win_ev | (|rise);
        if (win_ev) begin
            ev_frame.code = CODE_WIN;
            ev_frame.rw   = req_we;
            ev_frame.addr = 16'(req_addr);
        end else begin
            for (int i = NSIG - 1; i >= 0; i--) begin
                if (rise[i]) ev_frame.code = sig_code(i);
            end
        end
    end
endmodule

// File: rtl/ipg_frame_buf.sv
module ipg_frame_buf
    import ipg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ev_valid,
    input  frame_t      ev_frame,
    input  logic        eng_rd,
    input  logic        ovf_clr,
    output logic        frm_flag,
    output logic [15:0] frm_word,
    output logic        frm_ovf
);
    frame_t held;
    logic   pend;
    logic   beat;
    logic   ovf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held  <= '0;
            pend  <= 1'b0;
            beat  <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            if (pend) begin
                if (eng_rd) begin
                    if (beat) begin
                        pend <= 1'b0;
                        beat <= 1'b0;
                    end else begin
                        beat <= 1'b1;
                    end
                end
                if (ev_valid) ovf_q <= 1'b1;
            end else if (ev_valid) begin
                held <= ev_frame;
                pend <= 1'b1;
            end
            if (ovf_clr) ovf_q <= 1'b0;
        end
    end

    assign frm_flag = pend;
    assign frm_ovf  = ovf_q;
    assign frm_word = !pend ? 16'h0 : (beat ? held[31:16] : held[15:0]);
endmodule

// File: rtl/ipg_wrapper.sv
module ipg_wrapper
    import ipg_pkg::*;
#(
    parameter int         NSIG     = 8,
    parameter int         AW       = 8,
    parameter int         WIN_BASE = 0,
    parameter int         WIN_SIZE = 16,
    parameter logic [3:0] WRAP_ID  = 4'h3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_addr,
    input  logic [15:0]     cfg_wdata,
    input  logic [NSIG-1:0] mon_sig,
    input  logic            req_valid,
    input  logic            req_we,
    input  logic [AW-1:0]   req_addr,
    output logic            fwd_valid,
    output logic            fwd_we,
    output logic [AW-1:0]   fwd_addr,
    output logic            req_err,
    input  logic            eng_rd,
    output logic            frm_flag,
    output logic [15:0]     frm_word,
    output logic            frm_ovf
);
    logic [NSIG:0] mask_q;
    logic          dis_q;
    logic          ovf_clr;
    logic          win_hit;
    logic          ev_valid;
    frame_t        ev_frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            dis_q  <= 1'b0;
        end else if (cfg_we) begin
            if (cfg_addr == CFG_MASK)    mask_q <= cfg_wdata[NSIG:0];
            if (cfg_addr == CFG_DISABLE) dis_q  <= cfg_wdata[0];
        end
    end

    assign ovf_clr = cfg_we && (cfg_addr == CFG_OVFCLR);

    ipg_access_gate #(.AW(AW), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)) u_gate (
        .clk(clk), .rst(rst), .disable_on(dis_q),
        .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
        .fwd_valid(fwd_valid), .fwd_we(fwd_we), .fwd_addr(fwd_addr),
        .req_err(req_err), .win_hit(win_hit)
    );

    ipg_event_detect #(.NSIG(NSIG), .AW(AW), .WRAP_ID(WRAP_ID)) u_detect (
        .clk(clk), .rst(rst), .mask(mask_q), .mon_sig(mon_sig),
        .win_hit(win_hit), .req_we(req_we), .req_addr(req_addr),
        .ev_valid(ev_valid), .ev_frame(ev_frame)
    );

    ipg_frame_buf u_buf (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_frame(ev_frame),
        .eng_rd(eng_rd), .ovf_clr(ovf_clr),
        .frm_flag(frm_flag), .frm_word(frm_word), .frm_ovf(frm_ovf)
    );
endmodule

// File: rtl/ipg_wrapper_chk.sv
module ipg_wrapper_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_we,
    input logic [1:0]  cfg_addr,
    input logic        eng_rd,
    input logic        req_valid,
    input logic        fwd_valid,
    input logic        req_err,
    input logic        frm_flag,
    input logic [15:0] frm_word,
    input logic        frm_ovf
);
    AST_BLOCK_GIVES_ERR: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !fwd_valid) |=> req_err); // R8

    AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        req_err |-> $past(req_valid && !fwd_valid)); // R8

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (frm_flag && !eng_rd) |=> frm_flag); // R6

    AST_FRAME_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (frm_flag && !eng_rd) |=> $stable(frm_word)); // R7

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (frm_ovf && !(cfg_we && cfg_addr == 2'd2)) |=> frm_ovf); // R7
endmodule

bind ipg_wrapper ipg_wrapper_chk u_chk (.*);

// File: tb/ipg_wrapper_test.sv
module ipg_wrapper_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [1:0]  cfg_addr;
    logic [15:0] cfg_wdata;
    logic [7:0]  mon_sig;
    logic        req_valid, req_we;
    logic [7:0]  req_addr;
    logic        fwd_valid, fwd_we;
    logic [7:0]  fwd_addr;
    logic        req_err, eng_rd, frm_flag, frm_ovf;
    logic [15:0] frm_word;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    ipg_wrapper uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .mon_sig(mon_sig), .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
        .fwd_valid(fwd_valid), .fwd_we(fwd_we), .fwd_addr(fwd_addr), .req_err(req_err),
        .eng_rd(eng_rd), .frm_flag(frm_flag), .frm_word(frm_word), .frm_ovf(frm_ovf)
    );

    // {disable, write, addr[7:0], expected forward, expected error}
    localparam int NV = 7;
    localparam logic [11:0] VEC [NV] = '{
        {1'b0, 1'b0, 8'h07, 1'b1, 1'b0},
        {1'b0, 1'b1, 8'h20, 1'b1, 1'b0},
        {1'b1, 1'b0, 8'h05, 1'b0, 1'b1},
        {1'b1, 1'b1, 8'h0F, 1'b0, 1'b1},
        {1'b1, 1'b0, 8'h10, 1'b1, 1'b0},
        {1'b1, 1'b1, 8'hFF, 1'b1, 1'b0},
        {1'b1, 1'b0, 8'h00, 1'b0, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic read_frame(input string req, input logic [15:0] lo, input logic [15:0] hi);
        check(req, {31'd0, frm_flag}, 32'd1);
        eng_rd = 1'b1;
        #1 check(req, {16'd0, frm_word}, {16'd0, lo});
        step();
        check(req, {16'd0, frm_word}, {16'd0, hi});
        step();
        eng_rd = 1'b0;
        #1 check(req, {31'd0, frm_flag}, 32'd0);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; mon_sig = 0;
        req_valid = 0; req_we = 0; req_addr = 0; eng_rd = 0;
        step(); step(); step();
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 flag", {31'd0, frm_flag}, 0);
        check("R1 ovf", {31'd0, frm_ovf}, 0);
        check("R1 err", {31'd0, req_err}, 0);
        check("R1 word", {16'd0, frm_word}, 0);
        // R1: mask clear, so a signal edge gives no frame
        mon_sig = 8'h01; step(); mon_sig = 0; step();
        check("R1 mask clear", {31'd0, frm_flag}, 0);
        // R1: disable off, so a window request is forwarded
        req_valid = 1; req_addr = 8'h03; #1;
        check("R1 disable off", {31'd0, fwd_valid}, 1);
        step(); req_valid = 0;

        // table walk: access gate, R8 R9 (window reporting masked -> R3)
        for (int i = 0; i < NV; i++) begin
            cfg_write(2'd1, {15'd0, VEC[i][11]});
            req_valid = 1; req_we = VEC[i][10]; req_addr = VEC[i][9:2];
            #1;
            check("R8/R9 fwd_valid", {31'd0, fwd_valid}, {31'd0, VEC[i][1]});
            if (VEC[i][1]) begin
                check("R9 fwd_addr", {24'd0, fwd_addr}, {24'd0, VEC[i][9:2]});
                check("R9 fwd_we", {31'd0, fwd_we}, {31'd0, VEC[i][10]});
            end
            step();
            req_valid = 0;
            check("R8/R9 err pulse", {31'd0, req_err}, {31'd0, VEC[i][0]});
            step();
            check("R8 err one cycle", {31'd0, req_err}, 0);
            check("R3 no window frame", {31'd0, frm_flag}, 0);
        end

        // R10: disable still on after idle time
        for (int k = 0; k < 20; k++) step();
        req_valid = 1; req_addr = 8'h09; #1;
        check("R10 persists", {31'd0, fwd_valid}, 0);
        step(); req_valid = 0;
        cfg_write(2'd1, 16'd0);
        req_valid = 1; #1;
        check("R10 cleared", {31'd0, fwd_valid}, 1);
        step(); req_valid = 0;

        // R2 masked signal 2; R3 signal 5 unmasked
        cfg_write(2'd0, 16'h0004);
        mon_sig = 8'h20; step(); mon_sig = 0; step();
        check("R3 unmasked", {31'd0, frm_flag}, 0);
        mon_sig = 8'h04; step(); mon_sig = 0;
        check("R2 flag", {31'd0, frm_flag}, 1);
        check("R2 ovf", {31'd0, frm_ovf}, 0);
        read_frame("R2/R6 frame", 16'h0000, 16'h3300);

        // R4 + R5: window write while disabled, plus two signal edges
        cfg_write(2'd0, 16'h0112);
        cfg_write(2'd1, 16'd1);
        req_valid = 1; req_we = 1; req_addr = 8'h07; mon_sig = 8'h12;
        step();
        req_valid = 0; req_we = 0; mon_sig = 0;
        check("R8 blocked still reported", {31'd0, req_err}, 1);
        read_frame("R4/R5 window frame", 16'h0007, 16'h3F01);

        // R5 lowest index among signals
        mon_sig = 8'h12; step(); mon_sig = 0;
        // R7 collide while pending, then between beats
        step();
        mon_sig = 8'h02; step(); mon_sig = 0;
        check("R7 ovf set", {31'd0, frm_ovf}, 1);
        eng_rd = 1; step(); eng_rd = 0;
        mon_sig = 8'h10; step(); mon_sig = 0;
        check("R6 flag holds mid-read", {31'd0, frm_flag}, 1);
        check("R6 beat two", {16'd0, frm_word}, 32'h3200);
        eng_rd = 1; step(); eng_rd = 0;
        check("R6 drained", {31'd0, frm_flag}, 0);
        check("R7 sticky", {31'd0, frm_ovf}, 1);
        cfg_write(2'd2, 16'd0);
        check("R7 clear", {31'd0, frm_ovf}, 0);

        // R7: event on closing beat is overflow, old frame kept
        mon_sig = 8'h02; step(); mon_sig = 0;
        eng_rd = 1; step();
        mon_sig = 8'h10; step(); mon_sig = 0; eng_rd = 0;
        check("R7 final-beat collide flag", {31'd0, frm_flag}, 0);
        check("R7 final-beat collide ovf", {31'd0, frm_ovf}, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule